// File: doc/BRIEF.md
# Modem Handshake Control and Status Register

This block keeps the host-written modem control bits and turns them into the two active-low handshake outputs, request-to-send and terminal-ready. It also watches four active-low status pins: clear-to-send, data-set-ready, ring and carrier-detect. Each pin passes through a synchroniser. The block then offers an 8-bit status word. The upper half of that word holds the live signal levels. The lower half holds change flags, which stay set until the host reads the status word.

Three of the change flags (clear-to-send, data-set-ready and carrier-detect) respond to any change of their input. The ring flag responds in one direction only: it sets when the ring pin returns high, which marks the end of a ring. While any change flag is set and the interrupt enable is high, the block raises an interrupt request. A loopback control bit drives both handshake outputs inactive. In loopback, the block feeds its own control bits to the status path in place of the pins.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset, rts_n and dtr_n are high, msr_rdata is 0x00, irq is low and ctrl_rdata is 0.
- R2: A write with ctrl_we loads ctrl_wdata into the control register, readable on ctrl_rdata from the next cycle. The field layout is: bit 0 terminal-ready, bit 1 request-to-send, bit 2 aux1, bit 3 aux2, bit 4 loopback. Outside loopback, dtr_n is the inverse of bit 0 and rts_n is the inverse of bit 1.
- R3: msr_rdata bits 4, 5, 6 and 7 show the asserted (active-high) state of cts_n, dsr_n, ri_n and dcd_n, in that order. A pin change reaches these bits SYNC_STAGES clock edges after it is applied.
- R4: msr_rdata bits 0, 1 and 3 set on any change of the synchronised clear-to-send, data-set-ready and carrier-detect levels, respectively. Each bit sets one edge after the level bit changes.
- R5: msr_rdata bit 2 sets only when ri_n goes from low to high. A high-to-low change of ri_n leaves bit 2 clear.
- R6: A cycle with msr_rd high clears bits 0 to 3 at its clock edge. A change detected on that same edge still sets its bit.
- R7: irq is high exactly when irq_en is high and at least one of msr_rdata bits 0 to 3 is set.
- R8: With the loopback bit set, rts_n and dtr_n are high from the next cycle and the status pins are ignored. The status path then sees request-to-send as clear-to-send, terminal-ready as data-set-ready, aux1 as ring and aux2 as carrier-detect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control register write data |
| ctrl_rdata | output | 5 | Control register contents |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| msr_rd | input | 1 | Status read strobe, clears change flags |
| msr_rdata | output | 8 | Status word: change flags low, levels high |
| irq_en | input | 1 | Modem status interrupt enable |
| irq | output | 1 | Modem status interrupt request |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2. This lets the bench predict, from the parameter, both the edge at which a level bit moves and the edge at which its change flag sets. With that timing known, the bench can place a status read on exactly the edge where a new change is detected, which is the case R6 requires. It can also hold pin activity during loopback long enough to show that the pins have no effect on the status word.

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [4:0] ctrl_wdata,
  output logic [4:0] ctrl_rdata,
  output logic       rts_n,
  output logic       dtr_n,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       msr_rd,
  output logic [7:0] msr_rdata,
  input  logic       irq_en,
  output logic       irq
);

  logic [4:0] mcr;
  logic       loop_on;
  logic [3:0] src;
  logic [SYNC_STAGES-1:0][3:0] sync_q;
  logic [3:0] lvl;
  logic [3:0] prev;
  logic [3:0] chg;
  logic [3:0] delta;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mcr <= '0;
    else if (ctrl_we) mcr <= ctrl_wdata;

  assign loop_on    = mcr[4];
  assign ctrl_rdata = mcr;
  assign rts_n      = ~(mcr[1] & ~loop_on);
  assign dtr_n      = ~(mcr[0] & ~loop_on);

  assign src = loop_on ? {mcr[3], mcr[2], mcr[0], mcr[1]}
                       : ~{dcd_n, ri_n, dsr_n, cts_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= src;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  assign lvl = sync_q[SYNC_STAGES-1];

  assign chg = {lvl[3] ^ prev[3], ~lvl[2] & prev[2], lvl[1] ^ prev[1], lvl[0] ^ prev[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev  <= '0;
      delta <= '0;
    end else begin
      prev  <= lvl;
      delta <= (msr_rd ? 4'b0 : delta) | chg;
    end

  assign msr_rdata = {lvl, delta};
  assign irq       = irq_en & (|delta);

  // R8
  loop_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[4]) |=> (rts_n && dtr_n));

  // R4
  delta_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[0] != prev[0]) |=> msr_rdata[0]);

  // R5
  teri_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[2] && !prev[2] && !msr_rdata[2]) |=> !msr_rdata[2]);

  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && lvl == prev) |=> (msr_rdata[3:0] == 4'b0));

  // R6
  delta_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_rd && msr_rdata[1]) |=> msr_rdata[1]);

endmodule

// File: tb/modem_ctl_stat_bench.sv
module modem_ctl_stat_bench;
  localparam int SYNC = 2;
  localparam int NV = 6;
  // {dcd_n, ri_n, dsr_n, cts_n, expected status}
  localparam logic [11:0] VEC [NV] = '{
    {4'b1110, 8'h11},
    {4'b1100, 8'h32},
    {4'b1000, 8'h70},
    {4'b1100, 8'h34},
    {4'b0101, 8'hA9},
    {4'b1111, 8'h0A}
  };

  logic clk = 0, rst_n = 0, ctrl_we = 0, msr_rd = 0, irq_en = 0;
  logic [4:0] ctrl_wdata = '0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic [4:0] ctrl_rdata;
  logic rts_n, dtr_n, irq;
  logic [7:0] msr_rdata;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  modem_ctl_stat #(.SYNC_STAGES(SYNC)) u_modem_ctl_stat (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .rts_n(rts_n), .dtr_n(dtr_n), .cts_n(cts_n),
    .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n), .msr_rd(msr_rd),
    .msr_rdata(msr_rdata), .irq_en(irq_en), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SYNC + 2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd();
    msr_rd = 1;
    @(posedge clk);
    @(negedge clk);
    msr_rd = 0;
  endtask

  task automatic wr(input logic [4:0] d);
    ctrl_wdata = d; ctrl_we = 1;
    @(posedge clk);
    @(negedge clk);
    ctrl_we = 0;
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 msr", msr_rdata, 8'h00);
    chk("R1 outs", {6'b0, rts_n, dtr_n}, 8'h03);
    chk("R1 irq/ctrl", {2'b0, irq, ctrl_rdata}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    wr(5'b00011);
    chk("R2 ctrl", {3'b0, ctrl_rdata}, 8'h03);
    chk("R2 outs", {6'b0, rts_n, dtr_n}, 8'h00);
    wr(5'b00010);
    chk("R2 dtr off", {6'b0, rts_n, dtr_n}, 8'h01);

    irq_en = 1;
    for (int i = 0; i < NV; i++) begin
      {dcd_n, ri_n, dsr_n, cts_n} = VEC[i][11:8];
      settle();
      chk($sformatf("R3 R4 R5 vec%0d", i), msr_rdata, VEC[i][7:0]);
      chk($sformatf("R7 vec%0d", i), {7'b0, irq}, {7'b0, |VEC[i][3:0]});
      rd();
      chk($sformatf("R6 clear vec%0d", i), msr_rdata, {VEC[i][7:4], 4'h0});
    end

    irq_en = 0;
    dsr_n = 0;
    settle();
    chk("R7 masked msr", msr_rdata, 8'h22);
    chk("R7 masked irq", {7'b0, irq}, 8'h00);
    irq_en = 1; #1;
    chk("R7 enabled irq", {7'b0, irq}, 8'h01);
    rd();
    chk("R7 cleared irq", {7'b0, irq}, 8'h00);
    dsr_n = 1;
    settle();
    rd();

    cts_n = 0;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    rd();
    chk("R6 collision kept", msr_rdata, 8'h11);
    rd();
    chk("R6 plain clear", msr_rdata, 8'h10);
    cts_n = 1;
    settle();
    rd();

    wr(5'b11010);
    chk("R8 outs forced", {6'b0, rts_n, dtr_n}, 8'h03);
    chk("R2 R8 ctrl", {3'b0, ctrl_rdata}, 8'h1A);
    settle();
    chk("R8 loop route", msr_rdata, 8'h99);
    rd();
    cts_n = 0; ri_n = 0;
    settle();
    chk("R8 pins ignored", msr_rdata, 8'h90);
    wr(5'b00000);
    cts_n = 1; ri_n = 1;
    settle();
    rd();
    chk("R8 exit", msr_rdata, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule